// File: doc/BRIEF.md
# GF(2^128) Field Multiplier

This block multiplies two elements of the binary field GF(2^128) and returns the fully reduced 128-bit product. An element is a 128-bit vector in which bit i is the coefficient of x^i. The vector is made of four 32-bit words, and word 0 sits in bits 31:0. Under this encoding the element one is word 0 equal to 1 with every other word zero.

A single shared 64x64 carry-less multiplier computes the four partial products of the two 64-bit operand halves, one per cycle, in this order: low·low, low·high, high·low, high·high. Each partial product is XORed into a 256-bit accumulator at bit 0, 64, 64 and 128 respectively. The accumulator is then reduced modulo x^128 + x^7 + x^2 + x + 1 in two stages. The first stage folds the top bits of the upper half back into its lowest word. The second stage XORs that folded value, shifted left by 0, 1, 2 and 7, into the lower half.

The control is a four-state machine:
- S_IDLE waits with `ready` high. On `start` it captures both operands and moves to S_PART.
- S_PART runs four cycles, one partial product per cycle. After the fourth it moves to S_FOLD.
- S_FOLD registers the reduced result and moves to S_FIN.
- S_FIN raises `done` for one cycle and returns to S_IDLE.

Top module: `gfm128_mul`

## Requirements
- R1: While reset is asserted and after it is released, `ready` is 1, `done` is 0 and `result` is all zeros.
- R2: Operands and result use the bit-i-is-x^i encoding, with word 0 in bits 31:0. For example, x (value 2 in word 0) times x^32 (value 1 in word 1) gives value 2 in word 1.
- R3: Multiplying any operand by one (128'h1), on either side, returns that operand unchanged.
- R4: Multiplying any operand by zero, on either side, returns zero.
- R5: The product is commutative: a·b and b·a give the same result.
- R6: Reduction uses the polynomial x^128 + x^7 + x^2 + x + 1. Both x^127·x and x^64·x^64 return 128'h87.
- R7: For arbitrary operands, `result` equals the product computed bit-serially by shift-and-reduce with tail 128'h87.
- R8: `start` is accepted only on a rising edge at which `ready` is 1. `ready` is low in the cycle after acceptance.
- R9: If an operation is accepted at edge k, `done` is high only in the cycle after edge k+5. `ready` returns to 1 after edge k+6.
- R10: `result` changes only on the edge that raises `done`. It then holds its value until the next operation completes.
- R11: `start`, or new operand values, presented while the block is busy have no effect. The operation in flight completes with its captured operands, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiplication; sampled only while ready is high |
| op_a | input | 128 | First field operand, word 0 in bits 31:0 |
| op_b | input | 128 | Second field operand, word 0 in bits 31:0 |
| ready | output | 1 | High in S_IDLE; a new operation may be started |
| done | output | 1 | One-cycle pulse in S_FIN; result is valid |
| result | output | 128 | Reduced product, held until the next completion |

## Verification
An accepted `start` lowers `ready` after one edge. `done` and the new `result` appear after the fifth edge that follows acceptance, and `ready` returns after the sixth. The bench drives `start` on a falling edge and counts rising edges from the acceptance edge. It samples on the falling edges, so it checks that `done` is low for the first four cycles and high in exactly the fifth. On the cycle after `done`, the bench confirms that `done` has dropped, `ready` is back and `result` has not moved. The product value is compared only at the sampled `done` cycle, against a bit-serial reference computed in the bench.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 4;
    localparam int FE_W    = WORD_W * N_WORDS;
    localparam int HALF_W  = FE_W / 2;
    localparam int PROD_W  = 2 * FE_W;
    localparam logic [FE_W-1:0] POLY_TAIL = 128'h87;

    typedef logic [FE_W-1:0] fe_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PART = 2'd1,
        S_FOLD = 2'd2,
        S_FIN  = 2'd3
    } gfm_state_e;
endpackage

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
    parameter int W = 64
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    // Carry-less product: XOR of shifted copies of a for each set bit of b.
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) begin
                p = p ^ ({{W{1'b0}}, a} << i);
            end
        end
    end
endmodule

// File: rtl/gfm_fold.sv
module gfm_fold #(
    parameter int              FW   = 128,
    parameter logic [FW-1:0]   TAIL = 128'h87
) (
    input  logic [2*FW-1:0] wide,
    output logic [FW-1:0]   res
);
    logic [FW-1:0] hi_part;
    logic [FW-1:0] lo_part;
    logic [FW-1:0] folded;

    assign hi_part = wide[2*FW-1:FW];
    assign lo_part = wide[FW-1:0];

    // Stage one: bits of the upper half that would overflow after the
    // second-stage shifts are folded down into the low word.
    always_comb begin
        folded = hi_part;
        for (int k = 1; k < FW; k++) begin
            if (TAIL[k]) begin
                folded = folded ^ (hi_part >> (FW - k));
            end
        end
    end

    // Stage two: add the folded value times the tail polynomial.
    always_comb begin
        res = lo_part;
        for (int k = 0; k < FW; k++) begin
            if (TAIL[k]) begin
                res = res ^ (folded << k);
            end
        end
    end
endmodule

// File: rtl/gfm128_mul.sv
module gfm128_mul
    import gfm_pkg::*;
#(
    parameter int PARTS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [FE_W-1:0] op_a,
    input  logic [FE_W-1:0] op_b,
    output logic            ready,
    output logic            done,
    output logic [FE_W-1:0] result
);
    localparam int IDX_W    = $clog2(PARTS);
    localparam int LAST_IDX = PARTS - 1;

    gfm_state_e        state, nxt;
    fe_t               a_q, b_q, res_q;
    logic [IDX_W-1:0]  idx;
    logic [PROD_W-1:0] acc;

    logic [HALF_W-1:0] a_half, b_half;
    logic [FE_W-1:0]   part;
    logic [PROD_W-1:0] part_placed;
    fe_t               reduced;
    int                part_shift;

    // Partial product select: idx bit 1 picks half of a, bit 0 half of b.
    assign a_half     = idx[1] ? a_q[FE_W-1:HALF_W] : a_q[HALF_W-1:0];
    assign b_half     = idx[0] ? b_q[FE_W-1:HALF_W] : b_q[HALF_W-1:0];
    assign part_shift = (int'(idx[1]) + int'(idx[0])) * HALF_W;
    assign part_placed = {{FE_W{1'b0}}, part} << part_shift;

    gfm_clmul #(.W(HALF_W)) u_clmul (
        .a (a_half),
        .b (b_half),
        .p (part)
    );

    gfm_fold #(.FW(FE_W), .TAIL(POLY_TAIL)) u_fold (
        .wide (acc),
        .res  (reduced)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Transitions.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_PART;
            S_PART: if (idx == IDX_W'(LAST_IDX)) nxt = S_FOLD;
            S_FOLD: nxt = S_FIN;
            S_FIN:  nxt = S_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            idx   <= '0;
            acc   <= '0;
            res_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    a_q <= op_a;
                    b_q <= op_b;
                    idx <= '0;
                    acc <= '0;
                end
                S_PART: begin
                    acc <= acc ^ part_placed;
                    idx <= idx + 1'b1;
                end
                S_FOLD: res_q <= reduced;
                S_FIN:  ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        ready  = (state == S_IDLE);
        done   = (state == S_FIN);
        result = res_q;
    end

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> (!ready && !done));
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_fold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == S_FOLD));
    p_ready_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && done));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !done && state != S_FOLD) |=> !done);
endmodule

// File: tb/tb_gfm128_mul.sv
`timescale 1ns/1ps
module tb_gfm128_mul;
    import gfm_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    fe_t  op_a = '0;
    fe_t  op_b = '0;
    logic ready, done;
    fe_t  result;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    always #2 clk = ~clk;

    gfm128_mul dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b),
        .ready(ready), .done(done), .result(result)
    );

    function automatic fe_t ref_mul(input fe_t a, input fe_t b);
        fe_t r = '0;
        for (int i = FE_W - 1; i >= 0; i--) begin
            logic top;
            top = r[FE_W-1];
            r = r << 1;
            if (top) r = r ^ 128'h87;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic fe_t rnd_fe();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string req, input fe_t act, input fe_t exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // One operation with protocol checks (R8, R9, R10). With poke set,
    // start and altered operands are applied mid-operation (R11).
    task automatic run_op(input fe_t a, input fe_t b, input bit poke, output fe_t r);
        bit lat_ok = 1'b1;
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(!ready && !done, "R8", {126'b0, ready, done}, '0);
        for (int i = 1; i <= 5; i++) begin
            if (poke && i == 2) begin
                op_a = ~a; op_b = a ^ b; start = 1'b1;
            end
            if (poke && i == 3) begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            if (i < 5 && done) lat_ok = 1'b0;
            if (i == 5 && !done) lat_ok = 1'b0;
        end
        check(lat_ok, "R9", {127'b0, done}, 128'h1);
        r = result;
        @(posedge clk);
        @(negedge clk);
        check(!done && ready && result == r, "R10", result, r);
    endtask

    task automatic t_reset();
        check(ready && !done && result == '0, "R1", result, '0);
    endtask

    task automatic t_encoding();
        fe_t r;
        run_op(128'h2, 128'h1_0000_0000, 1'b0, r);
        check(r == 128'h2_0000_0000, "R2", r, 128'h2_0000_0000);
    endtask

    task automatic t_identity();
        fe_t a = rnd_fe();
        fe_t r;
        run_op(a, 128'h1, 1'b0, r);
        check(r == a, "R3", r, a);
        run_op(128'h1, a, 1'b0, r);
        check(r == a, "R3", r, a);
    endtask

    task automatic t_zero();
        fe_t a = rnd_fe();
        fe_t r;
        run_op(a, '0, 1'b0, r);
        check(r == '0, "R4", r, '0);
        run_op('0, a, 1'b0, r);
        check(r == '0, "R4", r, '0);
    endtask

    task automatic t_commute();
        for (int n = 0; n < 3; n++) begin
            fe_t a = rnd_fe();
            fe_t b = rnd_fe();
            fe_t r1, r2;
            run_op(a, b, 1'b0, r1);
            run_op(b, a, 1'b0, r2);
            check(r1 == r2, "R5", r2, r1);
        end
    endtask

    task automatic t_tail();
        fe_t r;
        run_op(fe_t'(1) << 127, 128'h2, 1'b0, r);
        check(r == 128'h87, "R6", r, 128'h87);
        run_op(fe_t'(1) << 64, fe_t'(1) << 64, 1'b0, r);
        check(r == 128'h87, "R6", r, 128'h87);
    endtask

    task automatic t_random();
        fe_t r, e;
        run_op('1, '1, 1'b0, r);
        e = ref_mul('1, '1);
        check(r == e, "R7", r, e);
        for (int n = 0; n < 20; n++) begin
            fe_t a = rnd_fe();
            fe_t b = rnd_fe();
            run_op(a, b, 1'b0, r);
            e = ref_mul(a, b);
            check(r == e, "R7", r, e);
        end
    endtask

    task automatic t_busy();
        fe_t a = rnd_fe();
        fe_t b = rnd_fe();
        fe_t r, e;
        bit quiet = 1'b1;
        run_op(a, b, 1'b1, r);
        e = ref_mul(a, b);
        check(r == e, "R11", r, e);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done || !ready || result != r) quiet = 1'b0;
        end
        check(quiet, "R11", result, r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ready && !done && result == '0, "R1", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_encoding();
        t_identity();
        t_zero();
        t_commute();
        t_tail();
        t_random();
        t_busy();
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!reported) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
            $finish;
        end
    end
endmodule